// File: doc/BRIEF.md
# EDO Page-Mode DRAM Device Control Logic

This block is a clock-sampled model of the control and data path inside a 16-bit DRAM with extended-data-out page mode. A fast system clock samples the active-low row strobe, two column strobes (one per byte lane), the write strobe and the output enable. Each is passed through a two-flop synchronizer, and edges are found by comparing each sample with the one before it. The multiplexed address bus and the input data go through the same pipeline, so they stay aligned with the strobes.

A falling row strobe latches the row. The first column strobe to fall latches the column. Further column cycles under the same row form a page, which ends when the row strobe rises. The order of the write strobe, the column strobes and the output enable decides whether a cycle is a read, an early write, a late write (read-modify-write), or a late write that is cancelled. Reads load a data latch. That latch keeps driving the output after the column strobe rises, which gives extended-data-out behaviour. Storage is a small internal array that is cleared at reset.

Top module: `edo_dram_ctl`

## Requirements
- R1: After reset `dq_oe_o` is 0 and every array word reads back as 0x0000.
- R2: A falling `ras_ni` latches the row from `addr_i`, and the first column strobe falling latches the column. While `ras_ni` stays low, each later column cycle addresses a new column in the same row.
- R3: A column strobe falling while `we_ni` is high is a read. The addressed word is loaded into the output latch and appears on `dq_o` with `dq_oe_o`=1 while `ras_ni` and `oe_ni` are low.
- R4: After a read, the output data stays driven and unchanged when the column strobes rise, as long as `ras_ni` and `oe_ni` stay low.
- R5: On writes, `casl_ni` enables data bits 7:0 and `cash_ni` enables bits 15:8. A lane whose strobe is high keeps its stored value.
- R6: When `we_ni` is low before (or together with) a column strobe fall, the cycle is an early write. Each falling lane stores `dq_i`, and `dq_oe_o` stays 0 whatever `oe_ni` does.
- R7: When `we_ni` falls while a column strobe is already low from a read and `oe_ni` is high, the cycle is a late write. The lanes whose strobes are low store `dq_i`.
- R8: When `we_ni` falls in the same situation but with `oe_ni` low, no write takes place and the outputs keep driving the read data.
- R9: Pulsing `oe_ni` high while `ras_ni` and a column strobe are low makes `dq_oe_o` 0 during the pulse. Afterwards the same data is driven again.
- R10: When `oe_ni` goes high and returns low after the column strobes have risen, with `ras_ni` still low, `dq_oe_o` stays 0 until the next read column cycle.
- R11: `ras_ni` rising ends the page and sets `dq_oe_o` to 0.
- R12: Each strobe, address or data change at the pins takes effect on the outputs no later than three clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| casl_ni | input | 1 | Column strobe for the low byte, active low |
| cash_ni | input | 1 | Column strobe for the high byte, active low |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| dq_i | input | 16 | Write data from the shared bus |
| dq_o | output | 16 | Read data toward the shared bus |
| dq_oe_o | output | 1 | Drive enable for the shared bus |

## Verification
The assertions assume that every pin stays stable for at least three sampling clocks between changes. They also assume that the row strobe falls in an earlier sample than any column strobe, so the row is latched before the column. The stimulus changes one group of strobes at a time and then waits four clocks before it samples or drives again. It always presents the address and data together with, or before, the strobe that captures them.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_EARLY = 2'd2,
    ACC_LATE  = 2'd3
  } acc_e;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned LANES       = 2;
endpackage

// File: rtl/edo_sync.sv
module edo_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= RST_VAL;
      else if (g == 0) st_q[g] <= d_i;
      else st_q[g] <= st_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/edo_array.sv
module edo_array #(
  parameter int unsigned ROW_W  = 4,
  parameter int unsigned COL_W  = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ROW_W-1:0]    row_i,
  input  logic [COL_W-1:0]    col_i,
  input  logic                wr_en_i,
  input  logic [1:0]          be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int unsigned DEPTH = (1 << (ROW_W + COL_W));
  localparam int unsigned LANE_W = DATA_W / 2;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [ROW_W+COL_W-1:0] idx;

  assign idx = {row_i, col_i};

  for (genvar l = 0; l < 2; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i][l*LANE_W +: LANE_W] <= '0;
      end else if (wr_en_i && be_i[l]) begin
        mem_q[idx][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rdata_o = mem_q[idx];
endmodule

// File: rtl/edo_ctl.sv
module edo_ctl
  import edo_pkg::*;
#(
  parameter int unsigned ROW_W  = 4,
  parameter int unsigned COL_W  = 5,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_i,
  input  logic              casl_i,
  input  logic              cash_i,
  input  logic              we_i,
  input  logic              oe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              wr_en_o,
  output logic [1:0]        wr_be_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic p_ras, p_cl, p_ch, p_we, p_oe;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [DATA_W-1:0] edo_q;
  logic armed_q;
  acc_e mode_q;

  logic ras_fall, ras_rel, cl_f, ch_f, cas_any, cas_start, we_f, oe_rel;
  logic late_evt, late_ok, late_abort, rd_load;
  logic [1:0] lane_early;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) {p_ras, p_cl, p_ch, p_we, p_oe} <= '0;
    else {p_ras, p_cl, p_ch, p_we, p_oe} <= {ras_i, casl_i, cash_i, we_i, oe_i};
  end

  assign ras_fall  = ras_i & ~p_ras;
  assign ras_rel   = ~ras_i & p_ras;
  assign cl_f      = casl_i & ~p_cl;
  assign ch_f      = cash_i & ~p_ch;
  assign cas_any   = casl_i | cash_i;
  assign cas_start = cas_any & ~(p_cl | p_ch);
  assign we_f      = we_i & ~p_we;
  assign oe_rel    = ~oe_i & p_oe;

  // early: WE already low when a lane falls
  assign lane_early = {ch_f, cl_f} & {2{we_i & ras_i}};
  // late: WE falls under a read column cycle
  assign late_evt   = we_f & (p_cl | p_ch) & cas_any & ras_i & (mode_q == ACC_READ);
  assign late_ok    = late_evt & ~oe_i;
  assign late_abort = late_evt & oe_i;
  assign rd_load    = cas_start & ~we_i & ras_i;

  assign wr_be_o = lane_early | (late_ok ? {cash_i, casl_i} : 2'b00);
  assign wr_en_o = |wr_be_o;
  assign row_o   = row_q;
  assign col_o   = cas_start ? addr_i[COL_W-1:0] : col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      if (ras_fall)  row_q <= addr_i[ROW_W-1:0];
      if (cas_start) col_q <= addr_i[COL_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= ACC_IDLE;
      armed_q <= 1'b0;
      edo_q   <= '0;
    end else if (ras_rel) begin
      mode_q  <= ACC_IDLE;
      armed_q <= 1'b0;
    end else if (rd_load) begin
      mode_q  <= ACC_READ;
      armed_q <= 1'b1;
      edo_q   <= rdata_i;
    end else if (cas_start && we_i) begin
      mode_q  <= ACC_EARLY;
      armed_q <= 1'b0;
    end else if (late_ok) begin
      mode_q  <= ACC_LATE;
      armed_q <= 1'b0;
    end else if (oe_rel && !cas_any) begin
      armed_q <= 1'b0;
    end
  end

  assign dq_oe_o = armed_q & ras_i & oe_i;
  assign dq_o    = dq_oe_o ? edo_q : '0;

  assert_ras_end_hiz_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_rel |=> !dq_oe_o);
  assert_early_hiz_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == ACC_EARLY) |-> !dq_oe_o);
  assert_abort_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_abort |=> (armed_q && $stable(edo_q)));
  assert_edo_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o && $past(dq_oe_o) && !$past(rd_load)) |-> $stable(dq_o));
  assert_write_needs_we_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (we_i && ras_i && cas_any));
endmodule

// File: rtl/edo_dram_ctl.sv
module edo_dram_ctl
  import edo_pkg::*;
#(
  parameter int unsigned ROW_W  = 4,
  parameter int unsigned COL_W  = 5,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              casl_ni,
  input  logic              cash_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  localparam int unsigned BUS_W = ADDR_W + DATA_W;

  logic [4:0] strb_n_s;
  logic [BUS_W-1:0] bus_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s, rdata;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic wr_en;
  logic [1:0] wr_be;

  edo_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11111)) i_sync_strb (
    .clk_i, .rst_ni,
    .d_i({ras_ni, casl_ni, cash_ni, we_ni, oe_ni}),
    .q_o(strb_n_s)
  );

  edo_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_sync_bus (
    .clk_i, .rst_ni,
    .d_i({addr_i, dq_i}),
    .q_o(bus_s)
  );

  assign {addr_s, data_s} = bus_s;

  edo_ctl #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctl (
    .clk_i, .rst_ni,
    .ras_i(~strb_n_s[4]), .casl_i(~strb_n_s[3]), .cash_i(~strb_n_s[2]),
    .we_i(~strb_n_s[1]), .oe_i(~strb_n_s[0]),
    .addr_i(addr_s), .rdata_i(rdata),
    .row_o(row), .col_o(col), .wr_en_o(wr_en), .wr_be_o(wr_be),
    .dq_o, .dq_oe_o
  );

  edo_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) i_array (
    .clk_i, .rst_ni,
    .row_i(row), .col_i(col), .wr_en_i(wr_en), .be_i(wr_be),
    .wdata_i(data_s), .rdata_o(rdata)
  );
endmodule

// File: tb/test_edo_dram_ctl.sv
module test_edo_dram_ctl;
  localparam int unsigned ROW_W = 4, COL_W = 5, DW = 16, AW = 5;

  logic clk = 0, rst_n = 0;
  logic ras_n = 1, cl_n = 1, ch_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0, dout;
  logic doe;
  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] ref_mem [1 << (ROW_W + COL_W)];

  always #10 clk = ~clk;

  edo_dram_ctl i_edo_dram_ctl (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .casl_ni(cl_n), .cash_ni(ch_n),
    .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr), .dq_i(din), .dq_o(dout), .dq_oe_o(doe)
  );

  task automatic step();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic open_row(logic [ROW_W-1:0] r);
    addr = AW'(r); step(); ras_n = 0; step();
  endtask

  task automatic close_row();
    cl_n = 1; ch_n = 1; we_n = 1; oe_n = 1; step(); ras_n = 1; step();
  endtask

  // read one column, check driven data and EDO hold
  task automatic t_read(logic [ROW_W-1:0] r, logic [COL_W-1:0] c, string req);
    open_row(r);
    oe_n = 0; we_n = 1; addr = AW'(c); step();
    cl_n = 0; ch_n = 0; step();
    chk({req, " oe"}, 32'(doe), 1);
    chk({req, " data"}, 32'(dout), 32'(ref_mem[{r, c}]));
    cl_n = 1; ch_n = 1; step();
    chk("R4 hold oe", 32'(doe), 1);
    chk("R4 hold data", 32'(dout), 32'(ref_mem[{r, c}]));
    ras_n = 1; step();
    chk("R11 page end hiz", 32'(doe), 0);
    oe_n = 1; step();
  endtask

  task automatic t_reset();
    chk("R1 reset hiz", 32'(doe), 0);
    t_read(4'd3, 5'd17, "R1 reset zero");
  endtask

  task automatic t_early_write();
    open_row(4'd2);
    oe_n = 0; we_n = 0; addr = 5'd4; din = 16'h1234; step();
    cl_n = 0; ch_n = 0; step();
    ref_mem[{4'd2, 5'd4}] = 16'h1234;
    chk("R6 early hiz with oe low", 32'(doe), 0);
    cl_n = 1; ch_n = 1; step();
    // second page column, low lane only
    addr = 5'd5; din = 16'hABCD; step();
    cl_n = 0; step();
    ref_mem[{4'd2, 5'd5}] = 16'h00CD;
    chk("R6 early hiz lane", 32'(doe), 0);
    close_row();
    t_read(4'd2, 5'd4, "R6 early stored");
    t_read(4'd2, 5'd5, "R5 low lane only");
  endtask

  task automatic t_page_read();
    open_row(4'd2);
    oe_n = 0; addr = 5'd4; step();
    cl_n = 0; ch_n = 0; step();
    chk("R2 page col a", 32'(dout), 32'h1234);
    cl_n = 1; ch_n = 1; addr = 5'd5; step();
    cl_n = 0; ch_n = 0; step();
    chk("R2 page col b", 32'(dout), 32'h00CD);
    close_row();
  endtask

  task automatic t_late_write();
    open_row(4'd7);
    oe_n = 0; addr = 5'd9; step();
    ch_n = 0; step();
    chk("R3 read before late", 32'(dout), 0);
    oe_n = 1; din = 16'h5A5A; step();
    chk("R7 oe off before data", 32'(doe), 0);
    we_n = 0; step();
    ref_mem[{4'd7, 5'd9}] = 16'h5A00;
    close_row();
    t_read(4'd7, 5'd9, "R7 late high lane");
    t_read(4'd7, 5'd9, "R5 high lane only");
  endtask

  task automatic t_abort();
    open_row(4'd7);
    oe_n = 0; addr = 5'd9; step();
    cl_n = 0; ch_n = 0; step();
    din = 16'hFFFF; we_n = 0; step();
    chk("R8 abort still driving", 32'(doe), 1);
    chk("R8 abort read data", 32'(dout), 32'h5A00);
    close_row();
    t_read(4'd7, 5'd9, "R8 abort no write");
  endtask

  task automatic t_oe_pulse();
    open_row(4'd2);
    oe_n = 0; addr = 5'd4; step();
    cl_n = 0; ch_n = 0; step();
    oe_n = 1; step();
    chk("R9 pulse hiz", 32'(doe), 0);
    oe_n = 0; step();
    chk("R9 pulse back oe", 32'(doe), 1);
    chk("R9 pulse same data", 32'(dout), 32'h1234);
    close_row();
  endtask

  task automatic t_oe_after_cas();
    open_row(4'd2);
    oe_n = 0; addr = 5'd4; step();
    cl_n = 0; ch_n = 0; step();
    cl_n = 1; ch_n = 1; step();
    oe_n = 1; step(); oe_n = 0; step();
    chk("R10 stays hiz", 32'(doe), 0);
    addr = 5'd5; step();
    cl_n = 0; ch_n = 0; step();
    chk("R10 next cas drives", 32'(doe), 1);
    chk("R10 next cas data", 32'(dout), 32'h00CD);
    close_row();
  endtask

  task automatic t_latency();
    open_row(4'd2);
    oe_n = 0; addr = 5'd4; step();
    @(negedge clk); cl_n = 0; ch_n = 0;
    repeat (2) @(negedge clk);
    chk("R12 not yet at two edges", 32'(doe), 0);
    @(negedge clk);
    chk("R12 valid at three edges", 32'(doe), 1);
    close_row();
  endtask

  initial begin
    foreach (ref_mem[i]) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_early_write();
    t_page_read();
    t_late_write();
    t_abort();
    t_oe_pulse();
    t_oe_after_cas();
    t_latency();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule